// File: doc/BRIEF.md
# Spiking Network Tile Sequencer

This controller drives one timestep-synchronous pass of a spiking network that has been compiled into a list of tiles. Each tile connects one group of 16 source neurons to one group of 16 destination neurons. Any group may feed any other, so recurrent networks are allowed. For every timestep the controller reads the tile descriptors in order, one per cycle. For each tile it issues three block-RAM read addresses: the source spike vector, the weight tile and the destination membrane potentials. The matching write-back strobes come out a fixed number of cycles later, when the crossbar results arrive. No tile is skipped: tiles without spike activity are visited too.

Consecutive tiles that share a destination group form a run. Their currents are accumulated, and the group's potentials and spikes are written back once, at the end of the run. Spikes are double-buffered. During a timestep, reads use one buffer and writes go to the other. Once the pipeline has drained after the last tile, the buffers swap and the next timestep begins. After the configured number of timesteps the controller pulses `done` and returns to idle.

Top module: `tile_seq_ctrl`

## Requirements
- R1: A start pulse sampled while idle, with a valid configuration, starts an inference. The first descriptor read is issued in the following cycle.
- R2: Within a timestep, descriptor reads are issued on consecutive cycles with addresses 0 to N-1, where N is `cfg_num_tiles`.
- R3: The descriptor read data is valid in the cycle after its read. Bits [1:0] hold the source group, bits [3:2] the destination group and bits [11:4] the weight base address (default parameters).
- R4: Tile k's read addresses are valid on `iss_*` exactly 3 cycles after its descriptor read. The weight address equals the weight base and the potential address equals the destination group.
- R5: `iss_spk_addr` is {read buffer bit, source group} and `wb_spk_addr` is {the other bit, destination group}. The read buffer bit is 0 in the first timestep of an inference and alternates every timestep.
- R6: Each tile gives one `wb_acc_en` cycle, DATA_LAT (2) cycles after its issue cycle. `wb_acc_clr` marks the first tile of a run and `wb_commit` marks the last tile of a run. The first and last tiles of a timestep always start and end a run.
- R7: Consecutive timesteps begin N+5+DATA_LAT cycles apart, allowing for drain and buffer swap.
- R8: `done` is high for exactly one cycle, S*(N+5+DATA_LAT) cycles after the first descriptor read, where S is `cfg_num_steps`. No reads or strobes occur in that cycle.
- R9: A start pulse during an inference is ignored, and the schedule is unchanged.
- R10: A start pulse with zero tiles, zero timesteps, or more than MAX_TILES tiles is ignored. No reads are issued and no `done` is raised.
- R11: During reset, every read enable, strobe and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an inference |
| cfg_num_tiles | input | 5 | Tiles per timestep, sampled at start |
| cfg_num_steps | input | 8 | Timesteps per inference, sampled at start |
| desc_rd_en | output | 1 | Descriptor memory read enable |
| desc_rd_addr | output | 4 | Descriptor index |
| desc_rd_data | input | 12 | Descriptor word, one cycle after read |
| iss_valid | output | 1 | Tile read addresses valid |
| iss_spk_addr | output | 3 | Spike buffer read address {buffer, group} |
| iss_w_addr | output | 8 | Weight tile base address |
| iss_pot_addr | output | 2 | Potential read address (destination group) |
| wb_acc_en | output | 1 | Crossbar currents arrive for accumulation |
| wb_acc_clr | output | 1 | Start a new accumulation run |
| wb_commit | output | 1 | Write back potentials and spikes of the run |
| wb_pot_addr | output | 2 | Potential write address |
| wb_spk_addr | output | 3 | Spike write address {buffer, group} |
| done | output | 1 | One-cycle completion pulse |

## Verification
All results can be timed from the cycle in which start is sampled. Reads begin one cycle later. Tile k is issued at step cycle k+3 and written back at k+3+DATA_LAT. Each timestep lasts N+5+DATA_LAT cycles, and `done` arrives at S times that period. The bench counts cycles from the first read, reduces the count modulo the period to a step index and a step cycle, and compares every output at the falling edge in every cycle. Each check derives the expected address, flag or buffer bit from the descriptor pattern the bench loaded.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2,
      ST_SWAP  = 2'd3
   } tsc_state_e;

   // Run-boundary markers carried alongside each tile.
   typedef struct packed {
      logic first;
      logic last;
   } tsc_edge_t;

endpackage

// File: rtl/tsc_step_fsm.sv
module tsc_step_fsm #(
   parameter int TIDX_W    = 4,
   parameter int TCNT_W    = 5,
   parameter int STEP_W    = 8,
   parameter int MAX_TILES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [TCNT_W-1:0] cfg_tiles,
   input  logic [STEP_W-1:0] cfg_steps,
   input  logic              pipe_busy,
   output logic              rd_en,
   output logic [TIDX_W-1:0] rd_idx,
   output logic              cur_buf,
   output logic              done
);
   import tsc_pkg::*;

   tsc_state_e        state_q;
   logic [TIDX_W-1:0] tile_q;
   logic [TCNT_W-1:0] n_tiles_q;
   logic [STEP_W-1:0] n_steps_q;
   logic [STEP_W-1:0] step_q;
   logic              buf_q;
   logic              done_q;
   logic              cfg_ok;
   logic              last_tile;
   logic              last_step;

   assign cfg_ok    = (cfg_tiles != '0) && (cfg_steps != '0) &&
                      (cfg_tiles <= TCNT_W'(MAX_TILES));
   assign last_tile = (TCNT_W'(tile_q) == n_tiles_q - TCNT_W'(1));
   assign last_step = (step_q == n_steps_q - STEP_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tile_q    <= '0;
         n_tiles_q <= '0;
         n_steps_q <= '0;
         step_q    <= '0;
         buf_q     <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start && cfg_ok) begin
                  n_tiles_q <= cfg_tiles;
                  n_steps_q <= cfg_steps;
                  tile_q    <= '0;
                  step_q    <= '0;
                  buf_q     <= 1'b0;
                  state_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (last_tile) state_q <= ST_DRAIN;
               else           tile_q  <= tile_q + TIDX_W'(1);
            end
            ST_DRAIN: begin
               if (!pipe_busy) state_q <= ST_SWAP;
            end
            ST_SWAP: begin
               buf_q <= ~buf_q;
               if (last_step) begin
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  step_q  <= step_q + STEP_W'(1);
                  tile_q  <= '0;
                  state_q <= ST_RUN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_en   = (state_q == ST_RUN);
   assign rd_idx  = tile_q;
   assign cur_buf = buf_q;
   assign done    = done_q;

endmodule

// File: rtl/tsc_desc_fetch.sv
module tsc_desc_fetch #(
   parameter  int GIDX_W  = 2,
   parameter  int WADDR_W = 8,
   parameter  int TIDX_W  = 4,
   localparam int DESC_W  = WADDR_W + 2 * GIDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic [TIDX_W-1:0]   rd_idx,
   input  logic [DESC_W-1:0]   rd_data,
   input  logic                cur_buf,
   output logic                iss_valid,
   output logic [GIDX_W:0]     iss_spk_addr,
   output logic [WADDR_W-1:0]  iss_w_addr,
   output logic [GIDX_W-1:0]   iss_dst,
   output tsc_pkg::tsc_edge_t  iss_edge,
   output logic                busy
);
   logic               vld_q;
   logic               idx0_q;
   logic [GIDX_W-1:0]  new_src;
   logic [GIDX_W-1:0]  new_dst;
   logic [WADDR_W-1:0] new_w;

   // One-tile lookahead: a held tile is released once its successor is seen.
   logic               hold_vld;
   logic               hold_first;
   logic [GIDX_W-1:0]  hold_src;
   logic [GIDX_W-1:0]  hold_dst;
   logic [WADDR_W-1:0] hold_w;
   logic               emit_last;

   assign {new_w, new_dst, new_src} = rd_data;
   assign emit_last = !vld_q || (new_dst != hold_dst);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q        <= 1'b0;
         idx0_q       <= 1'b0;
         hold_vld     <= 1'b0;
         hold_first   <= 1'b0;
         hold_src     <= '0;
         hold_dst     <= '0;
         hold_w       <= '0;
         iss_valid    <= 1'b0;
         iss_spk_addr <= '0;
         iss_w_addr   <= '0;
         iss_dst      <= '0;
         iss_edge     <= '0;
      end else begin
         vld_q     <= rd_en;
         idx0_q    <= rd_en && (rd_idx == '0);
         iss_valid <= hold_vld;
         if (hold_vld) begin
            iss_spk_addr   <= {cur_buf, hold_src};
            iss_w_addr     <= hold_w;
            iss_dst        <= hold_dst;
            iss_edge.first <= hold_first;
            iss_edge.last  <= emit_last;
         end
         if (vld_q) begin
            hold_vld   <= 1'b1;
            hold_first <= idx0_q || (new_dst != hold_dst);
            hold_src   <= new_src;
            hold_dst   <= new_dst;
            hold_w     <= new_w;
         end else begin
            hold_vld   <= 1'b0;
         end
      end
   end

   assign busy = vld_q | hold_vld | iss_valid;

endmodule

// File: rtl/tsc_tag_align.sv
module tsc_tag_align #(
   parameter int TAG_W = 4,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_valid,
   output logic [TAG_W-1:0] out_tag,
   output logic             busy
);
   if (DEPTH == 0) begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign out_valid = in_valid;
      assign out_tag   = in_tag;
      assign busy      = 1'b0;
   end else begin : g_queue
      logic [DEPTH-1:0] stg_vld;
      logic [TAG_W-1:0] stg_tag [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_vld[0] <= 1'b0;
            stg_tag[0] <= '0;
         end else begin
            stg_vld[0] <= in_valid;
            stg_tag[0] <= in_tag;
         end
      end

      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stg_vld[i] <= 1'b0;
               stg_tag[i] <= '0;
            end else begin
               stg_vld[i] <= stg_vld[i-1];
               stg_tag[i] <= stg_tag[i-1];
            end
         end
      end

      assign out_valid = stg_vld[DEPTH-1];
      assign out_tag   = stg_tag[DEPTH-1];
      assign busy      = |stg_vld;
   end

endmodule

// File: rtl/tile_seq_ctrl.sv
module tile_seq_ctrl #(
   parameter  int N_GROUPS  = 4,
   parameter  int MAX_TILES = 16,
   parameter  int WADDR_W   = 8,
   parameter  int STEP_W    = 8,
   parameter  int DATA_LAT  = 2,
   localparam int GIDX_W    = $clog2(N_GROUPS),
   localparam int TIDX_W    = $clog2(MAX_TILES),
   localparam int TCNT_W    = $clog2(MAX_TILES + 1),
   localparam int DESC_W    = WADDR_W + 2 * GIDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [TCNT_W-1:0]  cfg_num_tiles,
   input  logic [STEP_W-1:0]  cfg_num_steps,
   output logic               desc_rd_en,
   output logic [TIDX_W-1:0]  desc_rd_addr,
   input  logic [DESC_W-1:0]  desc_rd_data,
   output logic               iss_valid,
   output logic [GIDX_W:0]    iss_spk_addr,
   output logic [WADDR_W-1:0] iss_w_addr,
   output logic [GIDX_W-1:0]  iss_pot_addr,
   output logic               wb_acc_en,
   output logic               wb_acc_clr,
   output logic               wb_commit,
   output logic [GIDX_W-1:0]  wb_pot_addr,
   output logic [GIDX_W:0]    wb_spk_addr,
   output logic               done
);
   import tsc_pkg::*;

   localparam int TAG_W = $bits(tsc_edge_t) + GIDX_W;

   if (N_GROUPS < 2 || (N_GROUPS & (N_GROUPS - 1)) != 0) begin : g_bad_groups
      $error("N_GROUPS must be a power of two of at least 2");
   end
   if (MAX_TILES < 2) begin : g_bad_tiles
      $error("MAX_TILES must be at least 2");
   end
   if (DATA_LAT < 0 || DATA_LAT > 16) begin : g_bad_lat
      $error("DATA_LAT must lie in 0..16");
   end
   if (WADDR_W < 1 || STEP_W < 1) begin : g_bad_width
      $error("address and step widths must be positive");
   end

   logic              cur_buf;
   logic              fetch_busy;
   logic              align_busy;
   logic              pipe_busy;
   logic [GIDX_W-1:0] iss_dst;
   tsc_edge_t         iss_edge;
   logic              wb_valid;
   logic [TAG_W-1:0]  wb_tag;
   tsc_edge_t         wb_edge;
   logic [GIDX_W-1:0] wb_dst;

   assign pipe_busy = fetch_busy | align_busy;

   tsc_step_fsm #(
      .TIDX_W   (TIDX_W),
      .TCNT_W   (TCNT_W),
      .STEP_W   (STEP_W),
      .MAX_TILES(MAX_TILES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cfg_tiles(cfg_num_tiles),
      .cfg_steps(cfg_num_steps),
      .pipe_busy(pipe_busy),
      .rd_en    (desc_rd_en),
      .rd_idx   (desc_rd_addr),
      .cur_buf  (cur_buf),
      .done     (done)
   );

   tsc_desc_fetch #(
      .GIDX_W (GIDX_W),
      .WADDR_W(WADDR_W),
      .TIDX_W (TIDX_W)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_en       (desc_rd_en),
      .rd_idx      (desc_rd_addr),
      .rd_data     (desc_rd_data),
      .cur_buf     (cur_buf),
      .iss_valid   (iss_valid),
      .iss_spk_addr(iss_spk_addr),
      .iss_w_addr  (iss_w_addr),
      .iss_dst     (iss_dst),
      .iss_edge    (iss_edge),
      .busy        (fetch_busy)
   );

   assign iss_pot_addr = iss_dst;

   tsc_tag_align #(
      .TAG_W(TAG_W),
      .DEPTH(DATA_LAT)
   ) u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (iss_valid),
      .in_tag   ({iss_edge, iss_dst}),
      .out_valid(wb_valid),
      .out_tag  (wb_tag),
      .busy     (align_busy)
   );

   assign {wb_edge, wb_dst} = wb_tag;
   assign wb_acc_en   = wb_valid;
   assign wb_acc_clr  = wb_valid & wb_edge.first;
   assign wb_commit   = wb_valid & wb_edge.last;
   assign wb_pot_addr = wb_dst;
   assign wb_spk_addr = {~cur_buf, wb_dst};

endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
   parameter int GIDX_W = 2,
   parameter int TIDX_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              desc_rd_en,
   input logic [TIDX_W-1:0] desc_rd_addr,
   input logic              iss_valid,
   input logic [GIDX_W:0]   iss_spk_addr,
   input logic              wb_acc_en,
   input logic              wb_acc_clr,
   input logic              wb_commit,
   input logic [GIDX_W-1:0] wb_pot_addr,
   input logic [GIDX_W:0]   wb_spk_addr,
   input logic              done
);

   assert_rd_consec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_rd_en && $past(desc_rd_en)) |->
         (desc_rd_addr == $past(desc_rd_addr) + TIDX_W'(1)));

   assert_iss_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> $past(desc_rd_en, 3));

   assert_buf_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && wb_acc_en) |-> (iss_spk_addr[GIDX_W] != wb_spk_addr[GIDX_W]));

   assert_run_cont_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_acc_en && !wb_acc_clr) |->
         ($past(wb_acc_en) && !$past(wb_commit) && (wb_pot_addr == $past(wb_pot_addr))));

   assert_run_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wb_acc_en) && !$past(wb_commit)) |-> (wb_acc_en && !wb_acc_clr));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!desc_rd_en && !iss_valid && !wb_acc_en));

endmodule

bind tile_seq_ctrl tsc_checker #(
   .GIDX_W(GIDX_W),
   .TIDX_W(TIDX_W)
) u_tsc_chk (.*);

// File: tb/tile_seq_ctrl_bench.sv
module tile_seq_ctrl_bench;
   localparam int NG   = 4;
   localparam int DLAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  cfg_num_tiles = '0;
   logic [7:0]  cfg_num_steps = '0;
   logic        desc_rd_en;
   logic [3:0]  desc_rd_addr;
   logic [11:0] desc_rd_data = '0;
   logic        iss_valid;
   logic [2:0]  iss_spk_addr;
   logic [7:0]  iss_w_addr;
   logic [1:0]  iss_pot_addr;
   logic        wb_acc_en, wb_acc_clr, wb_commit;
   logic [1:0]  wb_pot_addr;
   logic [2:0]  wb_spk_addr;
   logic        done;

   logic [11:0] rom [16];
   int e_src [16];
   int e_dst [16];
   int e_w   [16];
   int n_checks = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   always @(posedge clk) if (desc_rd_en) desc_rd_data <= rom[desc_rd_addr];

   tile_seq_ctrl u_tile_seq_ctrl (.*);

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic fill(int pat);
      for (int k = 0; k < 16; k++) begin
         case (pat)
            0: begin e_dst[k] = 2;           e_src[k] = k % 4;             e_w[k] = k * 7 + 1;    end
            1: begin e_dst[k] = (k / 2) % 4; e_src[k] = (k % 2 == 0) ? e_dst[k] : (e_dst[k] + 1) % 4;
                     e_w[k] = 200 - k * 3; end
            2: begin e_dst[k] = k % 4;       e_src[k] = 3 - (k % 4);       e_w[k] = k * 16 + 5;   end
            default: begin e_dst[k] = (k / 3) % 4; e_src[k] = (k * 5) % 4; e_w[k] = (k * 11) % 256; end
         endcase
         rom[k] = {8'(e_w[k]), 2'(e_dst[k]), 2'(e_src[k])};
      end
   endtask

   task automatic check_cycle(int t, int n, int s, int per);
      int j, r, k, k2;
      bit v, v2, exp_en, exp_clr, exp_cmt;
      if (t == s * per) begin
         chk(done == 1'b1, "R8", "done at end", int'(done), 1);
         chk(desc_rd_en == 1'b0 && iss_valid == 1'b0 && wb_acc_en == 1'b0, "R8", "quiet at done",
             int'(desc_rd_en | iss_valid | wb_acc_en), 0);
         return;
      end
      j = t / per;
      r = t % per;
      chk(done == 1'b0, "R8", "done early", int'(done), 0);
      exp_en = (r < n);
      if (t == 0)      chk(desc_rd_en == exp_en, "R1", "first read", int'(desc_rd_en), int'(exp_en));
      else if (r == 0) chk(desc_rd_en == exp_en, "R7", "step restart", int'(desc_rd_en), int'(exp_en));
      else             chk(desc_rd_en == exp_en, "R2", "read enable", int'(desc_rd_en), int'(exp_en));
      if (exp_en) chk(desc_rd_addr == 4'(r), "R2", "read address", int'(desc_rd_addr), r);
      k = r - 3;
      v = (k >= 0) && (k < n);
      chk(iss_valid == v, "R4", "issue valid", int'(iss_valid), int'(v));
      if (v) begin
         chk(int'(iss_spk_addr) == (j % 2) * NG + e_src[k], "R5", "spike read addr",
             int'(iss_spk_addr), (j % 2) * NG + e_src[k]);
         chk(int'(iss_w_addr) == e_w[k], "R3", "weight addr", int'(iss_w_addr), e_w[k]);
         chk(int'(iss_pot_addr) == e_dst[k], "R4", "potential addr", int'(iss_pot_addr), e_dst[k]);
      end
      k2 = r - 3 - DLAT;
      v2 = (k2 >= 0) && (k2 < n);
      exp_clr = v2 && (k2 == 0 || e_dst[k2] != e_dst[k2-1]);
      exp_cmt = v2 && (k2 == n - 1 || e_dst[k2+1] != e_dst[k2]);
      chk(wb_acc_en == v2, "R6", "acc enable", int'(wb_acc_en), int'(v2));
      chk(wb_acc_clr == exp_clr, "R6", "acc clear", int'(wb_acc_clr), int'(exp_clr));
      chk(wb_commit == exp_cmt, "R6", "commit", int'(wb_commit), int'(exp_cmt));
      if (v2) begin
         chk(int'(wb_pot_addr) == e_dst[k2], "R6", "wb potential addr", int'(wb_pot_addr), e_dst[k2]);
         chk(int'(wb_spk_addr) == ((j + 1) % 2) * NG + e_dst[k2], "R5", "spike write addr",
             int'(wb_spk_addr), ((j + 1) % 2) * NG + e_dst[k2]);
      end
   endtask

   task automatic run_case(int n, int s, int pat, bit poke);
      int per;
      per = n + 5 + DLAT;
      fill(pat);
      @(negedge clk);
      cfg_num_tiles = 5'(n);
      cfg_num_steps = 8'(s);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t <= s * per; t++) begin
         check_cycle(t, n, s, per);
         start = (poke && t == 4);   // R9: stray start mid-run
         @(negedge clk);
      end
      start = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk(desc_rd_en == 1'b0 && done == 1'b0, poke ? "R9" : "R8", "idle after done",
             int'(desc_rd_en | done), 0);
         @(negedge clk);
      end
   endtask

   task automatic bad_start(int n, int s);
      @(negedge clk);
      cfg_num_tiles = 5'(n);
      cfg_num_steps = 8'(s);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20; i++) begin
         chk(desc_rd_en == 1'b0 && done == 1'b0, "R10", "invalid config ignored",
             int'(desc_rd_en | done), 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL R8 watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      fill(0);
      repeat (2) @(negedge clk);
      // R11: reset quiet
      chk(desc_rd_en == 0 && iss_valid == 0 && wb_acc_en == 0 && wb_commit == 0 && done == 0,
          "R11", "reset outputs", int'(desc_rd_en | iss_valid | wb_acc_en | wb_commit | done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(desc_rd_en == 0 && done == 0, "R11", "after reset", int'(desc_rd_en | done), 0);

      run_case(1, 1, 0, 1'b0);
      run_case(4, 3, 0, 1'b0);
      run_case(6, 2, 1, 1'b1);
      run_case(16, 2, 2, 1'b0);
      run_case(16, 3, 3, 1'b1);

      bad_start(0, 2);
      bad_start(3, 0);
      bad_start(17, 1);

      for (int n = 1; n <= 16; n++) run_case(n, 2, n % 4, n == 7);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule